// File: doc/BRIEF.md
# Queue Interrupt Condition Selector

This block turns the status flags of 32 hardware queues into interrupt requests. Every queue supplies four flags from outside the block: empty, nearly empty, nearly full and full. A 3-bit selector per queue picks one of these flags, or the inverse of one, as that queue's interrupt condition. A rising edge of the chosen condition latches a status bit for the queue. The latched bit stays set until software clears it.

A per-queue enable mask decides which latched bits reach the single combined interrupt line. Software reaches the selectors, the mask and the latched status through a small word-wide register port. Writes take effect on the clock edge and reads are combinational. Software clears status bits by writing back the value it read: each 1 clears that bit.

Top module: `qirq_cond_irq`

## Requirements
- R1: After reset, every selector, every enable bit and every status bit reads 0, and `irq_o` is low.
- R2: Selectors sit at word addresses 0 to 3. Queue q uses bits [(q%8)*4+2 : (q%8)*4] of the word at address q/8. A selector keeps its value until it is written again.
- R3: The selector codes are: 0 = empty, 1 = nearly empty, 2 = nearly full, 3 = full. Codes 4, 5, 6 and 7 are the inverse of codes 0, 1, 2 and 3 in the same order.
- R4: Bit 3 of each 4-bit selector nibble is reserved. It always reads 0, and writing it has no effect.
- R5: The enable mask is at address 4, and bit q enables queue q. It reads back as written.
- R6: A queue's status bit sets on the clock edge that first samples its selected condition high after a cycle in which the condition was low. The bit then stays set until it is cleared. A condition that is high in the first cycle after reset counts as a rising edge.
- R7: Status is at address 5. A write there clears every bit that has a 1 in the written data and leaves the other bits unchanged. The clear takes effect at that clock edge.
- R8: If a queue's set event and a clear of the same bit fall on the same clock edge, the bit ends up set.
- R9: `irq_o` is high exactly while some queue has both its status bit and its enable bit set. Status bits still latch while their queue is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| flag_empty | input | 32 | Per-queue empty flag |
| flag_nempty | input | 32 | Per-queue nearly-empty flag |
| flag_nfull | input | 32 | Per-queue nearly-full flag |
| flag_full | input | 32 | Per-queue full flag |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Two functions can land on the same edge. A queue's condition can rise in the very cycle that software writes ones to the status word to clear that bit. A selector or enable write can also land in a cycle where the flags move. The bench provokes the first case on purpose: it raises one queue's empty flag at the edge that carries an all-ones status write, and then expects that bit to read back as set. Random flag traffic mixed with random register writes covers the second case. A behavioural reference model, compared every clock, judges the combined interrupt line and each readback.

// File: rtl/qirq_pkg.sv
package qirq_pkg;
    localparam int Q_PER_WORD = 8;
    localparam int NIBBLE_W   = 4;
    localparam int SEL_W      = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_EMPTY      = 3'd0,
        SEL_NEMPTY     = 3'd1,
        SEL_NFULL      = 3'd2,
        SEL_FULL       = 3'd3,
        SEL_NOT_EMPTY  = 3'd4,
        SEL_NOT_NEMPTY = 3'd5,
        SEL_NOT_NFULL  = 3'd6,
        SEL_NOT_FULL   = 3'd7
    } sel_code_e;
endpackage

// File: rtl/qirq_cond_pick.sv
module qirq_cond_pick
    import qirq_pkg::*;
(
    input  logic [3:0]       flags_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             hit_o
);
    logic raw;

    // flags_i: bit0 empty, bit1 nearly empty, bit2 nearly full, bit3 full
    always_comb begin
        raw   = flags_i[sel_i[1:0]];
        hit_o = sel_i[2] ? ~raw : raw;   // upper four codes invert (R3)
    end
endmodule

// File: rtl/qirq_event_latch.sv
module qirq_event_latch #(
    parameter int NUM_Q = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NUM_Q-1:0] cond_i,
    input  logic [NUM_Q-1:0] clr_i,
    output logic [NUM_Q-1:0] status_o
);
    typedef struct packed {
        logic [NUM_Q-1:0] prev;
        logic [NUM_Q-1:0] stat;
    } latch_t;

    latch_t s_d, s_q;
    logic [NUM_Q-1:0] rise;

    always_comb begin
        s_d      = s_q;
        rise     = cond_i & ~s_q.prev;
        s_d.prev = cond_i;
        s_d.stat = (s_q.stat & ~clr_i) | rise;   // set dominates clear
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign status_o = s_q.stat;

    p_hold_until_clear_r6: assert property (@(posedge clk) disable iff (rst)
        ((($past(status_o) & ~$past(clr_i)) & ~status_o) == '0));

    p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
        (($past(cond_i & ~s_q.prev) & ~status_o) == '0));
endmodule

// File: rtl/qirq_cond_irq.sv
module qirq_cond_irq
    import qirq_pkg::*;
#(
    parameter int NUM_Q  = 32,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_Q-1:0]  flag_empty,
    input  logic [NUM_Q-1:0]  flag_nempty,
    input  logic [NUM_Q-1:0]  flag_nfull,
    input  logic [NUM_Q-1:0]  flag_full,
    output logic              irq_o
);
    localparam int NUM_SEL_WORDS = NUM_Q / Q_PER_WORD;
    localparam int ADDR_EN       = NUM_SEL_WORDS;
    localparam int ADDR_STAT     = NUM_SEL_WORDS + 1;

    typedef struct packed {
        logic [NUM_Q-1:0][SEL_W-1:0] sel;
        logic [NUM_Q-1:0]            en;
    } cfg_t;

    cfg_t             cfg_d, cfg_q;
    logic [NUM_Q-1:0] cond;
    logic [NUM_Q-1:0] clr;
    logic [NUM_Q-1:0] status;

    always_comb begin
        cfg_d = cfg_q;
        clr   = '0;
        if (bus_wr) begin
            for (int q = 0; q < NUM_Q; q++) begin
                if (bus_addr == ADDR_W'(q / Q_PER_WORD))
                    cfg_d.sel[q] = bus_wdata[(q % Q_PER_WORD) * NIBBLE_W +: SEL_W];
            end
            if (bus_addr == ADDR_W'(ADDR_EN))
                cfg_d.en = bus_wdata[NUM_Q-1:0];
            if (bus_addr == ADDR_W'(ADDR_STAT))
                clr = bus_wdata[NUM_Q-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cfg_q <= '0;
        else     cfg_q <= cfg_d;
    end

    always_comb begin
        bus_rdata = '0;
        for (int q = 0; q < NUM_Q; q++) begin
            if (bus_addr == ADDR_W'(q / Q_PER_WORD))
                bus_rdata[(q % Q_PER_WORD) * NIBBLE_W +: SEL_W] = cfg_q.sel[q];
        end
        if (bus_addr == ADDR_W'(ADDR_EN))   bus_rdata[NUM_Q-1:0] = cfg_q.en;
        if (bus_addr == ADDR_W'(ADDR_STAT)) bus_rdata[NUM_Q-1:0] = status;
    end

    for (genvar g = 0; g < NUM_Q; g++) begin : g_pick
        qirq_cond_pick u_pick (
            .flags_i ({flag_full[g], flag_nfull[g], flag_nempty[g], flag_empty[g]}),
            .sel_i   (cfg_q.sel[g]),
            .hit_o   (cond[g])
        );
    end

    qirq_event_latch #(.NUM_Q(NUM_Q)) u_latch (
        .clk      (clk),
        .rst      (rst),
        .cond_i   (cond),
        .clr_i    (clr),
        .status_o (status)
    );

    assign irq_o = |(status & cfg_q.en);

    p_irq_needs_status_r9: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (status != '0));

    p_masked_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.en == '0) |-> !irq_o);

    p_reserved_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_addr < ADDR_W'(NUM_SEL_WORDS)) |-> ((bus_rdata & 32'h8888_8888) == '0));

    p_cfg_stable_r2: assert property (@(posedge clk) disable iff (rst)
        !bus_wr |=> $stable(cfg_q));
endmodule

// File: tb/qirq_cond_irq_bench.sv
module qirq_cond_irq_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] fe = '0, fne = '0, fnf = '0, ff = '0;
    logic        irq_o;

    int checks = 0;
    int fails  = 0;
    bit running = 1'b0;
    bit done = 1'b0;

    // reference model state
    int       m_sel [32];
    bit [31:0] m_en, m_stat, m_prev;

    always #4 clk = ~clk;

    qirq_cond_irq u_qirq_cond_irq (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .flag_empty(fe), .flag_nempty(fne), .flag_nfull(fnf), .flag_full(ff),
        .irq_o(irq_o)
    );

    function automatic bit model_cond(int q);
        bit v;
        case (m_sel[q] % 4)
            0: v = fe[q];
            1: v = fne[q];
            2: v = fnf[q];
            default: v = ff[q];
        endcase
        return (m_sel[q] >= 4) ? !v : v;
    endfunction

    function automatic bit [31:0] model_read(int a);
        bit [31:0] r = '0;
        if (a < 4) begin
            for (int k = 0; k < 8; k++) r[k*4 +: 3] = 3'(m_sel[a*8 + k]);
        end else if (a == 4) r = m_en;
        else if (a == 5) r = m_stat;
        return r;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int q = 0; q < 32; q++) m_sel[q] = 0;
            m_en = '0; m_stat = '0; m_prev = '0;
        end else begin
            bit [31:0] clrv;
            bit [31:0] cnow;
            clrv = (bus_wr && bus_addr == 3'd5) ? bus_wdata : '0;
            for (int q = 0; q < 32; q++) cnow[q] = model_cond(q);
            m_stat = (m_stat & ~clrv) | (cnow & ~m_prev);
            m_prev = cnow;
            if (bus_wr && bus_addr < 3'd4)
                for (int k = 0; k < 8; k++) m_sel[bus_addr*8 + k] = int'(bus_wdata[k*4 +: 3]);
            if (bus_wr && bus_addr == 3'd4) m_en = bus_wdata;
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // R9: combined line compared against model each cycle
    always @(negedge clk) begin
        if (running && !rst)
            check("R9 irq", {31'b0, irq_o}, {31'b0, |(m_stat & m_en)});
    end

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 3'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(string tag, int a);
        bus_wr = 1'b0; bus_addr = 3'(a);
        #1;
        check(tag, bus_rdata, model_read(a));
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(200000 * 8);
        checks++; fails++;
        $display("FAIL watchdog expired: actual=hang expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        running = 1'b1;
        @(negedge clk);
        // R1: reset state, flags all low so default "empty" selector does not fire
        for (int a = 0; a < 6; a++) begin
            rd("R1 reset value", a);
            check("R1 reset exact zero", bus_rdata, 32'h0);
        end
        check("R1 irq after reset", {31'b0, irq_o}, 32'h0);

        // R2/R4: packing and reserved bits
        wr(0, 32'hFFFF_FFFF);
        rd("R4 reserved masked", 0);
        check("R4 reserved reads zero", bus_rdata, 32'h7777_7777);
        wr(1, 32'h7654_3210);
        rd("R2 word1 readback", 1);
        wr(2, 32'h89AB_CDEF);
        rd("R4 word2 reserved", 2);
        check("R4 word2 value", bus_rdata, 32'h0123_4567);
        idle(2);
        rd("R2 word0 held", 0);

        // R3/R6: each queue selects code q%8; clear then drive flags
        for (int a = 0; a < 4; a++) wr(a, 32'h7654_3210);
        wr(5, 32'hFFFF_FFFF);
        rd("R7 cleared", 5);
        fe = 32'h0101_0101; fne = 32'h0202_0202; fnf = 32'h0404_0404; ff = 32'h0808_0808;
        idle(1);
        rd("R3 codes 0-3 fire", 5);
        fe = '1; fne = '1; fnf = '1; ff = '1;
        idle(1);
        rd("R6 held while high", 5);
        wr(5, 32'hFFFF_FFFF);
        rd("R7 clear all", 5);
        fe = '0; fne = '0; fnf = '0; ff = '0;
        idle(1);
        rd("R3 inverted codes fire", 5);

        // R5/R9: enables gate the line; status latches while disabled
        wr(4, 32'h0000_00F0);
        rd("R5 enable readback", 4);
        idle(2);
        wr(4, 32'h0000_0000);
        rd("R9 status kept while disabled", 5);
        wr(5, 32'h0000_00F0);
        rd("R7 partial clear", 5);

        // R8: set and clear on the same edge
        wr(0, 32'h0000_0000);
        wr(5, 32'hFFFF_FFFF);
        @(negedge clk);
        fe[0] = 1'b1;
        bus_wr = 1'b1; bus_addr = 3'd5; bus_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        bus_wr = 1'b0;
        rd("R8 set wins", 5);
        check("R8 bit0 set", {31'b0, bus_rdata[0]}, 32'h1);

        // mixed random traffic
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            fe = $urandom; fne = $urandom; fnf = $urandom; ff = $urandom;
            if ($urandom_range(0, 3) == 0) begin
                bus_wr = 1'b1; bus_addr = 3'($urandom_range(0, 5)); bus_wdata = $urandom;
            end else begin
                bus_wr = 1'b0;
                rd("R2 R5 R6 R7 random readback", $urandom_range(0, 5));
            end
        end
        @(negedge clk);
        bus_wr = 1'b0;
        idle(2);
        running = 1'b0;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule